// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a real-time-clock peripheral that keeps a 32-bit count of seconds. A divider turns the input clock into a one-per-second tick. A 32-bit frequency word programs the divider with the input clock rate in Hz. Software reaches the block through a simple 16-bit register interface with write and read strobes, so every 32-bit quantity is split into a low half and a high half.

To set the time, software stages a value and raises a load request bit. To read the time, it raises a snapshot request bit. In both cases it polls until the hardware drops the bit. This way a 32-bit value always moves as one coherent word, even though the count keeps running while the two halves are accessed. An alarm latches a raw interrupt flag when the count takes the programmed match value. A mask gates that flag onto the interrupt line. A force bit and a clear bit let software set or drop the flag directly.

Top module: `sec_rtc`

## Requirements
- R1: After the synchronous reset, these registers read as follows: control 0x0021 (run-control bit set, mask set), frequency word 0x00008000, status 0, count snapshot 0. The interrupt output is 0.
- R2: The register word index is addr[5:2]:
  - 0: control
  - 1 / 2: frequency word low / high
  - 3 / 4: load value low / high
  - 5 / 6: match value low / high
  - 7: status
  - 8 / 9: count snapshot low / high

  The frequency, load and match halves read back exactly what was written. Read data appears on rdata one clock after the rd_en cycle.
- R3: With frequency word N (N at least 1) and control bit1 (count enable) at 1, the count advances by one on every Nth clock. The divider starts from zero after a control-bit0 clear. A word of 0 behaves as 1.
- R4: While control bit1 is 0, the count holds its value.
- R5: Writing 1 to control bit3 copies the 32-bit load value into the count one clock after the write. The bit then reads back as 0. A load takes precedence over a tick in the same clock.
- R6: Writing 1 to control bit4 copies the running count into the snapshot registers one clock after the write. The bit then returns to 0. The snapshot stays fixed while the count keeps running.
- R7: At count 0xFFFFFFFF, a tick gives 0 when control bit2 (wrap) is 1. When bit2 is 0, the count stays at 0xFFFFFFFF.
- R8: When the count is updated to a value equal to the match value, by tick or by load, status bit0 (raw flag) becomes 1. Status bit1 reads raw AND NOT mask, and irq follows it.
- R9: While control bit5 (mask) is 1, irq is 0 and status bit1 is 0. Status bit0 still records the alarm.
- R10: Writing 1 to control bit6 sets the raw flag. Writing 1 to control bit7 clears both status bits. Clear wins when both act in the same clock. Both bits read back as 0 afterwards.
- R11: While control bit0 is 0, the count, the tick divider and the raw flag are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address, word index in bits 5:2 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
Three cases are hard to reach from the ports: the wrap at 0xFFFFFFFF, the saturation hold, and an alarm landing at an exact tick. A free-running count would need billions of seconds to reach the top, so the stimulus loads values a few steps below it and programs small frequency words (including 0 and 1). Each run starts with a control-bit0 clear, so the divider phase is known. The bench can then predict the snapshot value for random wait lengths and compare it exactly. The same known phase puts the alarm on a known clock, where force, clear and mask interplay are checked.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  // control register bit positions (software decodes these)
  localparam int CB_RUN   = 0;  // 0 holds counter, divider and flag cleared
  localparam int CB_EN    = 1;
  localparam int CB_WRAP  = 2;
  localparam int CB_LOAD  = 3;
  localparam int CB_SNAP  = 4;
  localparam int CB_MASK  = 5;
  localparam int CB_FORCE = 6;
  localparam int CB_CLR   = 7;
  // status bit positions
  localparam int SB_RAW = 0;
  localparam int SB_ALM = 1;
  // word indices (addr[5:2])
  localparam int RW_CTRL   = 0;
  localparam int RW_FCW_LO = 1;
  localparam int RW_FCW_HI = 2;
  localparam int RW_LD_LO  = 3;
  localparam int RW_LD_HI  = 4;
  localparam int RW_MT_LO  = 5;
  localparam int RW_MT_HI  = 6;
  localparam int RW_STAT   = 7;
  localparam int RW_CNT_LO = 8;
  localparam int RW_CNT_HI = 9;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] fcw,
  output logic          tick
);
  logic [CW-1:0] div_q;
  logic [CW-1:0] lim;

  assign lim  = (fcw == '0) ? '0 : fcw - 1'b1;
  assign tick = run && (div_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= (div_q >= lim) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic          wrap,
  input  logic          load_go,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] match_val,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  always_comb begin
    upd   = 1'b0;
    cnt_d = cnt_q;
    if (load_go) begin
      upd   = 1'b1;
      cnt_d = load_val;
    end else if (tick) begin
      if (cnt_q != TOP) begin
        upd   = 1'b1;
        cnt_d = cnt_q + 1'b1;
      end else if (wrap) begin
        upd   = 1'b1;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign hit = upd && !clr && (cnt_d == match_val);
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status (
  input  logic clk,
  input  logic rst,
  input  logic clr_all,
  input  logic hit,
  input  logic force_go,
  input  logic clear_go,
  input  logic mask,
  output logic raw,
  output logic irq
);
  logic raw_q;

  always_ff @(posedge clk) begin
    if (rst || clr_all)       raw_q <= 1'b0;
    else if (clear_go)        raw_q <= 1'b0;
    else if (hit || force_go) raw_q <= 1'b1;
  end

  assign raw = raw_q;
  assign irq = raw_q & ~mask;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int          DW      = 16,
  parameter int          AW      = 6,
  parameter logic [31:0] FCW_RST = 32'd32768
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  import sec_rtc_pkg::*;

  localparam int CW   = 2 * DW;
  localparam int SELW = AW - 2;
  localparam logic [DW-1:0] CTRL_RST = DW'((1 << CB_RUN) | (1 << CB_MASK));

  logic [DW-1:0]   ctrl_q;
  logic [CW-1:0]   fcw_q, ld_q, mt_q, snap_q;
  logic [DW-1:0]   rdata_q;
  logic [SELW-1:0] word;
  logic [CW-1:0]   cnt_w;
  logic            tick_w, hit_w, raw_w, irq_w;
  logic            soft_clr, run_w, load_go, snap_go, force_go, clear_go;
  logic [1:0]      addr_lo_unused;

  assign word           = addr[AW-1:2];
  assign addr_lo_unused = addr[1:0];

  function automatic logic wsel(input int k);
    return wr_en && (word == SELW'(k));
  endfunction

  assign soft_clr = ~ctrl_q[CB_RUN];
  assign run_w    = ctrl_q[CB_EN] & ~soft_clr;
  assign load_go  = ctrl_q[CB_LOAD] & ~soft_clr;
  assign snap_go  = ctrl_q[CB_SNAP];
  assign force_go = ctrl_q[CB_FORCE];
  assign clear_go = ctrl_q[CB_CLR];

  // control register: request bits drop one clock after they are seen
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
    end else begin
      ctrl_q[CB_LOAD]  <= 1'b0;
      ctrl_q[CB_SNAP]  <= 1'b0;
      ctrl_q[CB_FORCE] <= 1'b0;
      ctrl_q[CB_CLR]   <= 1'b0;
      if (wsel(RW_CTRL)) ctrl_q <= wdata;
    end
  end

  // 32-bit values written as two halves
  always_ff @(posedge clk) begin
    if (rst) begin
      fcw_q <= FCW_RST;
      ld_q  <= '0;
      mt_q  <= '0;
    end else begin
      if (wsel(RW_FCW_LO)) fcw_q[DW-1:0]  <= wdata;
      if (wsel(RW_FCW_HI)) fcw_q[CW-1:DW] <= wdata;
      if (wsel(RW_LD_LO))  ld_q[DW-1:0]   <= wdata;
      if (wsel(RW_LD_HI))  ld_q[CW-1:DW]  <= wdata;
      if (wsel(RW_MT_LO))  mt_q[DW-1:0]   <= wdata;
      if (wsel(RW_MT_HI))  mt_q[CW-1:DW]  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (snap_go) snap_q <= cnt_w;
  end

  rtc_tick_div #(.CW(CW)) div_i (
    .clk(clk), .rst(rst), .clr(soft_clr), .run(run_w), .fcw(fcw_q), .tick(tick_w)
  );

  rtc_sec_counter #(.CW(CW)) cnt_i (
    .clk(clk), .rst(rst), .clr(soft_clr), .tick(tick_w), .wrap(ctrl_q[CB_WRAP]),
    .load_go(load_go), .load_val(ld_q), .match_val(mt_q), .cnt(cnt_w), .hit(hit_w)
  );

  rtc_irq_status irq_i (
    .clk(clk), .rst(rst), .clr_all(soft_clr), .hit(hit_w), .force_go(force_go),
    .clear_go(clear_go), .mask(ctrl_q[CB_MASK]), .raw(raw_w), .irq(irq_w)
  );

  // registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (word)
        SELW'(RW_CTRL):   rdata_q <= ctrl_q;
        SELW'(RW_FCW_LO): rdata_q <= fcw_q[DW-1:0];
        SELW'(RW_FCW_HI): rdata_q <= fcw_q[CW-1:DW];
        SELW'(RW_LD_LO):  rdata_q <= ld_q[DW-1:0];
        SELW'(RW_LD_HI):  rdata_q <= ld_q[CW-1:DW];
        SELW'(RW_MT_LO):  rdata_q <= mt_q[DW-1:0];
        SELW'(RW_MT_HI):  rdata_q <= mt_q[CW-1:DW];
        SELW'(RW_STAT):   rdata_q <= DW'({irq_w, raw_w});
        SELW'(RW_CNT_LO): rdata_q <= snap_q[DW-1:0];
        SELW'(RW_CNT_HI): rdata_q <= snap_q[CW-1:DW];
        default:          rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_w;
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     ctrl_q,
  input logic [2*DW-1:0]   cnt,
  input logic [2*DW-1:0]   ld,
  input logic [2*DW-1:0]   snap,
  input logic              raw,
  input logic              irq
);
  import sec_rtc_pkg::*;
  localparam logic [2*DW-1:0] TOP = '1;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr[AW-1:2] == '0);

  // R5: load lands one clock after the request
  a_r5_load_applies: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_LOAD] && ctrl_q[CB_RUN]) |=> (cnt == $past(ld)));

  // R5: load request drops unless rewritten
  a_r5_load_selfclear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_LOAD] && !(ctrl_wr && wdata[CB_LOAD])) |=> !ctrl_q[CB_LOAD]);

  // R4: disabled counter holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CB_EN] && !ctrl_q[CB_LOAD] && ctrl_q[CB_RUN]) |=> $stable(cnt));

  // R6: snapshot takes the running count
  a_r6_snapshot: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CB_SNAP] |=> (snap == $past(cnt)));

  // R7: saturation at the top
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_RUN] && !ctrl_q[CB_LOAD] && !ctrl_q[CB_WRAP] && cnt == TOP) |=> (cnt == TOP));

  // R9: masked line stays low
  a_r9_masked: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CB_MASK] |-> !irq);

  // R10: clear drops the raw flag
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_CLR] && ctrl_q[CB_RUN]) |=> !raw);

  // R11: soft reset zeroes count and flag
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CB_RUN] |=> (cnt == '0 && !raw));
endmodule

bind sec_rtc sec_rtc_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctrl_q(ctrl_q), .cnt(cnt_w), .ld(ld_q), .snap(snap_q), .raw(raw_w), .irq(irq)
);

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb_top;
  localparam logic [31:0] TOP = 32'hFFFF_FFFF;
  localparam int A_CTRL = 6'h00, A_FL = 6'h04, A_FH = 6'h08, A_LL = 6'h0C, A_LH = 6'h10;
  localparam int A_ML = 6'h14, A_MH = 6'h18, A_ST = 6'h1C, A_CL = 6'h20, A_CH = 6'h24;
  localparam logic [15:0] B_RUN = 16'h0001, B_EN = 16'h0002, B_WRAP = 16'h0004, B_LOAD = 16'h0008;
  localparam logic [15:0] B_SNAP = 16'h0010, B_MASK = 16'h0020, B_FORCE = 16'h0040, B_CLR = 16'h0080;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] shadow;

  always #5 clk = ~clk;

  sec_rtc dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int a, input logic [15:0] d);
    wr_en = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    rd_en = 1'b1; addr = 6'(a);
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr32(input int a, input logic [31:0] v);
    wr(a, v[15:0]); wr(a + 4, v[31:16]);
  endtask

  task automatic rd32(input int a, output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(a, lo); rd(a + 4, hi); v = {hi, lo};
  endtask

  // snapshot request, poll until dropped, then read both halves twice
  task automatic latch(output logic [31:0] v);
    logic [15:0] c;
    logic [31:0] v2;
    int tries = 0;
    wr(A_CTRL, shadow | B_SNAP);
    do begin rd(A_CTRL, c); tries++; end while (c[4] && tries < 8);
    chk("R6 snapshot request self-clears", 32'(c[4]), 32'd0);
    rd32(A_CL, v);
    rd32(A_CL, v2);
    chk("R6 snapshot stable while counting", v2, v);
  endtask

  // soft reset, then enable with a load: known divider phase from here
  task automatic start(input logic [31:0] l, input logic [31:0] n, input bit en,
                       input bit wrp, input bit msk);
    wr32(A_FL, n);
    wr32(A_LL, l);
    wr(A_CTRL, 16'h0000);
    shadow = B_RUN | (en ? B_EN : 16'h0) | (wrp ? B_WRAP : 16'h0) | (msk ? B_MASK : 16'h0);
    wr(A_CTRL, shadow | B_LOAD);
  endtask

  // count after m clocks past the start write
  function automatic logic [31:0] exp_cnt(input logic [31:0] l, input int m,
                                          input logic [31:0] n, input bit wrp);
    longint nn = (n == 0) ? 1 : longint'(n);
    longint q = longint'(m) / nn - ((nn == 1) ? 1 : 0);
    longint s = longint'(l) + q;
    if (wrp) return s[31:0];
    return (s > longint'(TOP)) ? TOP : s[31:0];
  endfunction

  task automatic run_and_check(input string req, input logic [31:0] l, input logic [31:0] n,
                               input int w, input bit wrp);
    logic [31:0] v;
    start(l, n, 1'b1, wrp, 1'b1);
    idle(w);
    latch(v);
    chk(req, v, exp_cnt(l, w + 1, n, wrp));
  endtask

  initial begin
    logic [15:0] d;
    logic [31:0] v;
    void'($urandom(32'd20240611));
    shadow = B_RUN | B_MASK;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(A_CTRL, d);   chk("R1 control reset", 32'(d), 32'h0021);
    rd32(A_FL, v);   chk("R1 frequency word reset", v, 32'h0000_8000);
    rd(A_ST, d);     chk("R1 status reset", 32'(d), 32'h0);
    rd32(A_CL, v);   chk("R1 snapshot reset", v, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // R2 readback of halves
    for (int i = 0; i < 4; i++) begin
      logic [31:0] f = $urandom, l = $urandom, m = $urandom;
      wr32(A_FL, f); wr32(A_LL, l); wr32(A_ML, m);
      rd32(A_FL, v); chk("R2 frequency readback", v, f);
      rd32(A_LL, v); chk("R2 load readback", v, l);
      rd32(A_ML, v); chk("R2 match readback", v, m);
    end
    wr32(A_ML, 32'h0000_0007);

    // R5 load with counting off, R4 hold
    start(32'h1234_5678, 32'd3, 1'b0, 1'b0, 1'b1);
    rd(A_CTRL, d);
    chk("R5 load request visible before completion", 32'(d[3]), 32'd1);
    rd(A_CTRL, d);
    chk("R5 load request self-clears", 32'(d[3]), 32'd0);
    idle(30);
    latch(v);
    chk("R4 count held while disabled", v, 32'h1234_5678);

    // R3 tick rate, directed words 0, 1, 2, 5
    run_and_check("R3 frequency word 0 acts as 1", 32'd100, 32'd0, 5, 1'b0);
    run_and_check("R3 frequency word 1", 32'd100, 32'd1, 9, 1'b0);
    run_and_check("R3 frequency word 2", 32'd0, 32'd2, 20, 1'b0);
    run_and_check("R3 frequency word 5", 32'd50, 32'd5, 33, 1'b0);

    // R7 wrap and saturate
    run_and_check("R7 wrap through zero", 32'hFFFF_FFFE, 32'd2, 5, 1'b1);
    run_and_check("R7 saturate at top", 32'hFFFF_FFFE, 32'd2, 5, 1'b0);

    // random runs
    for (int i = 0; i < 12; i++) begin
      logic [31:0] l = ($urandom % 3 == 0) ? TOP - ($urandom % 5) : $urandom;
      logic [31:0] n = $urandom % 10;
      int w = $urandom % 41;
      bit wp = 1'($urandom);
      run_and_check(wp ? "R3 R7 random run wrap" : "R3 R7 random run saturate", l, n, w, wp);
    end

    // R8 alarm by tick, unmasked: match 103 reached 6 clocks after start
    wr32(A_ML, 32'd103);
    start(32'd100, 32'd2, 1'b1, 1'b0, 1'b0);
    rd(A_ST, d);     chk("R8 no alarm before match", 32'(d), 32'h0);
    idle(8);
    rd(A_ST, d);     chk("R8 alarm status raw and masked", 32'(d), 32'h3);
    chk("R8 irq asserted", 32'(irq), 32'h1);
    wr(A_CTRL, shadow | B_CLR);
    idle(1);
    rd(A_ST, d);     chk("R10 clear drops status", 32'(d), 32'h0);
    chk("R10 irq dropped after clear", 32'(irq), 32'h0);
    rd(A_CTRL, d);   chk("R10 clear bit self-clears", 32'(d[7]), 32'd0);

    // R9 masked alarm
    start(32'd100, 32'd2, 1'b1, 1'b0, 1'b1);
    idle(8);
    rd(A_ST, d);     chk("R9 masked alarm sets raw only", 32'(d), 32'h1);
    chk("R9 irq low while masked", 32'(irq), 32'h0);
    shadow = shadow & ~B_MASK;
    wr(A_CTRL, shadow);
    chk("R9 irq follows unmask", 32'(irq), 32'h1);

    // R8 alarm by load
    wr32(A_ML, 32'hCAFE_0001);
    start(32'hCAFE_0001, 32'd4, 1'b0, 1'b0, 1'b1);
    idle(1);
    rd(A_ST, d);     chk("R8 alarm on load", 32'(d), 32'h1);

    // R10 force, and clear winning over force
    wr(A_CTRL, shadow | B_CLR);
    idle(1);
    wr(A_CTRL, shadow | B_FORCE);
    idle(1);
    rd(A_ST, d);     chk("R10 force sets raw", 32'(d[0]), 32'd1);
    rd(A_CTRL, d);   chk("R10 force bit self-clears", 32'(d[6]), 32'd0);
    wr(A_CTRL, shadow | B_FORCE | B_CLR);
    idle(1);
    rd(A_ST, d);     chk("R10 clear wins over force", 32'(d), 32'h0);

    // R11 soft reset clears count and flag
    wr32(A_ML, 32'd9);
    start(32'd9, 32'd3, 1'b1, 1'b0, 1'b0);
    idle(10);
    wr(A_CTRL, 16'h0000);
    shadow = B_RUN | B_MASK;
    wr(A_CTRL, shadow);
    latch(v);
    chk("R11 soft reset clears count", v, 32'h0);
    rd(A_ST, d);     chk("R11 soft reset clears status", 32'(d), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule